// File: doc/BRIEF.md
# Split Transaction Payload Segmenter

This block cuts an outgoing payload destined for a split transaction into pieces of at most 188 bytes. A one-cycle start pulse carries the total byte count and the data PID chosen by software. The block then offers segments one at a time on a valid/ready output stream. Each segment carries its byte count, a 2-bit code that gives its place in the payload, and the data PID to send with it.

Back-pressure rules: once `seg_valid_o` is high it stays high, and the segment fields hold steady, until the cycle in which `seg_ready_i` is also high. That cycle is the handshake. The next segment, if there is one, appears in the following cycle. The consumer may hold `seg_ready_i` low for any number of cycles. A start pulse is taken only while no transfer is in progress. After the handshake of the final segment, `done_o` pulses for one cycle. Moving the data, CRC and the hub handshake are handled elsewhere.

Top module: `seg_split_top`

## Requirements
- R1: After reset, `seg_valid_o` and `done_o` are low.
- R2: A start pulse taken while idle makes the first segment valid in the next cycle. A start pulse while a transfer is in progress is ignored and leaves that transfer's segments unchanged.
- R3: A payload of 0 to 188 bytes gives exactly one segment, with position code 2'b11 (whole) and a byte count equal to the payload length. A zero-length payload therefore gives one segment of 0 bytes.
- R4: A payload longer than 188 bytes begins with a segment of 188 bytes coded 2'b10 (first).
- R5: Every segment strictly between the first and the last carries 188 bytes and is coded 2'b00 (middle).
- R6: The last segment of a payload longer than 188 bytes is coded 2'b01 (final). It carries the length modulo 188, or 188 bytes when that remainder is zero. The number of segments is ceil(length/188), with a minimum of one.
- R7: The first segment carries the PID given with the start pulse. PID codes are 2'b00 DATA0, 2'b01 DATA2 and 2'b10 DATA1.
- R8: After each handshake the PID of the next segment is DATA1 if the current one was DATA0, and DATA0 otherwise.
- R9: While `seg_valid_o` is high and `seg_ready_i` is low, the next cycle still shows the same valid segment with unchanged byte count, code and PID.
- R10: `done_o` goes high for exactly one cycle, in the cycle after the last segment's handshake. In that cycle `seg_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new payload |
| start_len_i | input | LEN_W | Total payload byte count |
| start_pid_i | input | 2 | Initial data PID |
| seg_valid_o | output | 1 | A segment is offered |
| seg_ready_i | input | 1 | Consumer accepts the offered segment |
| seg_bytes_o | output | BYTES_W | Byte count of the offered segment |
| seg_pos_o | output | 2 | Position code of the offered segment |
| seg_pid_o | output | 2 | Data PID of the offered segment |
| done_o | output | 1 | One-cycle pulse after the final handshake |

## Verification
The assertions assume that the start PID is one of the three defined codes. They also assume that a start pulse lasts one cycle, although a start held while busy must still do no harm. The bench only ever drives the three legal PID codes and pulses start for a single cycle. It sweeps every length from 0 to 1100, plus the largest length, under three ready patterns: always ready, random stalls, and ready one cycle in three. Some runs also inject a conflicting start in the middle of a transfer to show that it is ignored.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;
  typedef enum logic [1:0] {
    POS_MID   = 2'b00,
    POS_FINAL = 2'b01,
    POS_FIRST = 2'b10,
    POS_WHOLE = 2'b11
  } seg_pos_e;

  localparam logic [1:0] PID_DATA0 = 2'b00;
  localparam logic [1:0] PID_DATA2 = 2'b01;
  localparam logic [1:0] PID_DATA1 = 2'b10;
endpackage

// File: rtl/seg_split_count.sv
module seg_split_count #(
  parameter int LEN_W     = 11,
  parameter int SEG_BYTES = 188,
  parameter int BYTES_W   = $clog2(SEG_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   start_len_i,
  input  logic               accept_i,
  output logic               busy_o,
  output logic               first_o,
  output logic               last_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               done_o
);
  localparam logic [LEN_W-1:0]   SEG_LEN = LEN_W'(SEG_BYTES);
  localparam logic [BYTES_W-1:0] SEG_B   = BYTES_W'(SEG_BYTES);

  logic [LEN_W-1:0] rem_q;
  logic             busy_q, first_q, done_q;

  assign last_o  = (rem_q <= SEG_LEN);
  assign bytes_o = last_o ? rem_q[BYTES_W-1:0] : SEG_B;
  assign busy_o  = busy_q;
  assign first_o = first_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        rem_q   <= start_len_i;
        first_q <= 1'b1;
        busy_q  <= 1'b1;
      end else if (busy_q && accept_i) begin
        first_q <= 1'b0;
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rem_q <= rem_q - SEG_LEN;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && accept_i && last_o) |=> (done_q && !busy_q)); // R10
  AST_BYTES_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bytes_o <= SEG_B)); // R5
endmodule

// File: rtl/seg_split_pos.sv
module seg_split_pos
  import seg_split_pkg::*;
(
  input  logic     first_i,
  input  logic     last_i,
  output seg_pos_e pos_o
);
  always_comb begin
    unique case ({first_i, last_i})
      2'b11:   pos_o = POS_WHOLE;
      2'b10:   pos_o = POS_FIRST;
      2'b01:   pos_o = POS_FINAL;
      default: pos_o = POS_MID;
    endcase
  end
endmodule

// File: rtl/seg_split_pid.sv
module seg_split_pid
  import seg_split_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] load_pid_i,
  input  logic       advance_i,
  output logic [1:0] pid_o
);
  logic [1:0] pid_q;
  assign pid_o = pid_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pid_q <= PID_DATA0;
    end else if (load_i) begin
      pid_q <= load_pid_i;
    end else if (advance_i) begin
      pid_q <= (pid_q == PID_DATA0) ? PID_DATA1 : PID_DATA0;
    end
  end

  AST_PID_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i) |=> (pid_q != $past(pid_q) && pid_q != PID_DATA2)); // R8
  AST_PID_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pid_q == $past(load_pid_i))); // R7
endmodule

// File: rtl/seg_split_top.sv
module seg_split_top
  import seg_split_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int SEG_BYTES = 188,
  localparam int BYTES_W  = $clog2(SEG_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   start_len_i,
  input  logic [1:0]         start_pid_i,
  output logic               seg_valid_o,
  input  logic               seg_ready_i,
  output logic [BYTES_W-1:0] seg_bytes_o,
  output logic [1:0]         seg_pos_o,
  output logic [1:0]         seg_pid_o,
  output logic               done_o
);
  logic     busy, first, last, accept, take_start;
  seg_pos_e pos;

  assign accept      = busy & seg_ready_i;
  assign take_start  = start_i & ~busy;
  assign seg_valid_o = busy;
  assign seg_pos_o   = pos;

  seg_split_count #(.LEN_W(LEN_W), .SEG_BYTES(SEG_BYTES), .BYTES_W(BYTES_W)) count_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_len_i(start_len_i),
    .accept_i   (accept),
    .busy_o     (busy),
    .first_o    (first),
    .last_o     (last),
    .bytes_o    (seg_bytes_o),
    .done_o     (done_o)
  );

  seg_split_pos pos_i (
    .first_i(first),
    .last_i (last),
    .pos_o  (pos)
  );

  seg_split_pid pid_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (take_start),
    .load_pid_i(start_pid_i),
    .advance_i (accept),
    .pid_o     (seg_pid_o)
  );

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_ready_i) |=> (seg_valid_o && $stable(seg_bytes_o)
      && $stable(seg_pos_o) && $stable(seg_pid_o))); // R9
  AST_START_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !seg_valid_o) |=> seg_valid_o); // R2
  AST_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_ready_i && seg_pos_o == 2'b10) |=>
      (seg_valid_o && (seg_pos_o == 2'b00 || seg_pos_o == 2'b01))); // R4
  AST_MID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_pos_o == 2'b00) |-> (seg_bytes_o == BYTES_W'(SEG_BYTES))); // R5
  AST_FINAL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_pos_o == 2'b01) |-> (seg_bytes_o != '0)); // R6
endmodule

// File: tb/seg_split_top_tb_top.sv
module seg_split_top_tb_top;
  localparam int LEN_W = 11;
  localparam int SEG   = 188;
  localparam int BW    = $clog2(SEG + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] start_len = '0;
  logic [1:0] start_pid = 2'b00;
  logic seg_valid, seg_ready = 1'b0, done;
  logic [BW-1:0] seg_bytes;
  logic [1:0] seg_pos, seg_pid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  seg_split_top #(.LEN_W(LEN_W), .SEG_BYTES(SEG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_len_i(start_len),
    .start_pid_i(start_pid), .seg_valid_o(seg_valid), .seg_ready_i(seg_ready),
    .seg_bytes_o(seg_bytes), .seg_pos_o(seg_pos), .seg_pid_o(seg_pid), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run(input int len, input logic [1:0] pid, input int mode, input bit poke);
    int rem = len;
    bit first = 1'b1;
    logic [1:0] epid = pid;
    int nseg = 0;
    int expseg = (len == 0) ? 1 : (len + SEG - 1) / SEG;
    bit done_loop = 1'b0;
    @(negedge clk);
    start = 1'b1; start_len = LEN_W'(len); start_pid = pid;
    @(negedge clk);
    start = 1'b0;
    check(seg_valid == 1'b1, "R2 valid after start", int'(seg_valid), 1);
    while (!done_loop) begin
      bit last = (rem <= SEG);
      int eb = last ? rem : SEG;
      int ep = first ? (last ? 3 : 2) : (last ? 1 : 0);
      bit rdy;
      check(seg_valid == 1'b1, "R9 valid held", int'(seg_valid), 1);
      check(int'(seg_bytes) == eb, ep == 3 ? "R3 bytes" : ep == 2 ? "R4 bytes" :
            ep == 0 ? "R5 bytes" : "R6 bytes", int'(seg_bytes), eb);
      check(int'(seg_pos) == ep, ep == 3 ? "R3 pos" : ep == 2 ? "R4 pos" :
            ep == 0 ? "R5 pos" : "R6 pos", int'(seg_pos), ep);
      check(seg_pid == epid, first ? "R7 pid" : "R8 pid", int'(seg_pid), int'(epid));
      check(done == 1'b0, "R10 no early done", int'(done), 0);
      case (mode)
        0: rdy = 1'b1;
        1: rdy = 1'($urandom % 2);
        default: rdy = ((cyc % 3) == 0);
      endcase
      if (poke && first) begin
        start = 1'b1; start_len = LEN_W'(len) ^ 11'h155; start_pid = 2'b01;
      end
      seg_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      seg_ready = 1'b0;
      if (rdy) begin
        nseg++;
        first = 1'b0;
        epid = (epid == 2'b00) ? 2'b10 : 2'b00;
        if (last) begin
          check(done == 1'b1, "R10 done pulse", int'(done), 1);
          check(seg_valid == 1'b0, "R10 idle at done", int'(seg_valid), 0);
          check(nseg == expseg, "R6 segment count", nseg, expseg);
          @(negedge clk);
          check(done == 1'b0, "R10 done one cycle", int'(done), 0);
          done_loop = 1'b1;
        end else begin
          rem -= SEG;
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(seg_valid == 1'b0, "R1 reset valid", int'(seg_valid), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_valid == 1'b0, "R1 idle after reset", int'(seg_valid), 0);
    for (int l = 0; l <= 1100; l++) begin
      logic [1:0] p = (l % 3 == 0) ? 2'b00 : (l % 3 == 1) ? 2'b01 : 2'b10;
      run(l, p, l % 3, (l % 5) == 0);
    end
    run((1 << LEN_W) - 1, 2'b10, 1, 1'b1);
    run(0, 2'b01, 2, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule